// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The block keeps a free-running 32-bit time counter on its reference clock. It logs events into a 16-entry first-in first-out queue. Each entry pairs the counter value at the moment of the event with a descriptor word. The descriptor identifies the source port, the kind of event, a message type and a sequence number.

Events come from several sources:
- a software command written over the register bus;
- rising edges on four hardware push pins, each enabled separately;
- receive and transmit strobes from an Ethernet port;
- two markers the unit makes itself: one when the counter wraps to zero, and one when its top bit sets.

Software reads the oldest entry through a time register and a descriptor register, then discards it with a pop write. A level interrupt tells software that entries are waiting. A test bit can force that interrupt.

The register bus is a plain 32-bit word bus. It has a byte address, a write strobe, write data and combinational read data. At most one event is recorded per clock. If several sources fire in the same clock, a fixed priority picks one, and the others are counted as lost in a sticky flag. The same flag records events dropped because the queue was full.

Top module: `tsync_capture`

## Requirements
- R1: After reset, all of the following read zero: the control word, raw and masked status, the time register (0x34), the descriptor register (0x38) and the interrupt output.
- R2: Address 0x00 reads a fixed identification word: ident[31:16], RTL version[15:11], major[10:8], minor[7:0], all taken from parameters.
- R3: Writing 1 to bit 0 of 0x14 loads the counter from the load-value register (0x10). While control bit 0 (enable) is set, the counter then advances by one per clock. While enable is clear, the counter holds its value.
- R4: Writing 1 to bit 0 of 0x0C records an event whose time is the counter value in the clock of the write. Its descriptor is type 0 with port 0.
- R5: A rising edge on hardware pin i (i = 0..3) records type 3 with port i+1 and the counter value of that clock. This happens only when control bit 8+i is set; a rising edge on a pin whose enable is clear is ignored.
- R6: A receive strobe records type 4 and a transmit strobe records type 5. The port, message type and sequence number come from that strobe's inputs. Descriptor layout: port[28:24], type[23:20], message[19:16], sequence[15:0], all other bits zero.
- R7: Counter increments from all ones to zero log type 1 with time 0. Increments that set bit 31 log type 2 with time 0x80000000. Counter loads log neither.
- R8: Entries come out in arrival order at 0x34/0x38. Writing 1 to bit 0 of 0x30 removes the head entry. With the queue empty, a pop has no effect and both head registers read zero.
- R9: The queue holds 16 entries, and an event arriving when it is full is dropped. A drop sets control bit 31, which stays set until software writes 1 to bit 1 of 0x30.
- R10: Only one event is recorded per clock. Priority runs: software push, then pins 0..3, then receive, transmit, wrap and half-wrap. Every other event arriving in the same clock is lost and sets control bit 31.
- R11: Raw status bit 0 (0x20) is 1 when the queue is non-empty or control bit 1 (test) is set. Masked status (0x24) and the interrupt output equal raw status ANDed with bit 0 of 0x28.
- R12: While enable is clear, no source records an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational |
| hw_push_pin | input | NUM_HW | Hardware push pins, rising edge active |
| rx_stb | input | 1 | Ethernet receive event strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence number |
| tx_stb | input | 1 | Ethernet transmit event strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence number |
| irq | output | 1 | Level interrupt |

## Verification
Several rules are checked on every cycle:
- the counter steps by one or holds, depending on enable;
- wrap and half-wrap markers line up with counter values of zero and 0x80000000;
- a full queue stays full and keeps its level when an event is dropped;
- a pop on an empty queue changes nothing;
- a full queue with a new event always sets the sticky flag;
- no entry is added while the unit is disabled.

Other behaviour can only be shown by the bench's scenarios. These include the exact timestamps and descriptor fields of each source, the arrival order and the priority pick among simultaneous events. They also include pins whose enable is clear, the effect of the flag-clear write, and the interrupt seen from both the test bit and queued entries.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

  typedef enum logic [3:0] {
    EV_SWPUSH = 4'd0,
    EV_WRAP   = 4'd1,
    EV_HALF   = 4'd2,
    EV_HWPUSH = 4'd3,
    EV_ETHRX  = 4'd4,
    EV_ETHTX  = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [2:0]  rsvd;
    logic [4:0]  port;
    ev_kind_e    kind;
    logic [3:0]  msg;
    logic [15:0] seq;
  } ev_desc_t;

  localparam logic [7:0] A_IDENT   = 8'h00;
  localparam logic [7:0] A_CTRL    = 8'h04;
  localparam logic [7:0] A_PUSH    = 8'h0C;
  localparam logic [7:0] A_LDVAL   = 8'h10;
  localparam logic [7:0] A_LDGO    = 8'h14;
  localparam logic [7:0] A_RAW     = 8'h20;
  localparam logic [7:0] A_MASKED  = 8'h24;
  localparam logic [7:0] A_IEN     = 8'h28;
  localparam logic [7:0] A_POP     = 8'h30;
  localparam logic [7:0] A_HTIME   = 8'h34;
  localparam logic [7:0] A_HDESC   = 8'h38;

endpackage

// File: rtl/tsync_counter.sv
module tsync_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         wrap_pulse,
  output logic         half_pulse
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         wrap_q, wrap_d, half_q, half_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    half_d = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (run) begin
      cnt_d  = cnt_q + W'(1);
      wrap_d = &cnt_q;
      half_d = !cnt_q[W-1] && cnt_d[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
      half_q <= half_d;
    end
  end

  assign count      = cnt_q;
  assign wrap_pulse = wrap_q;
  assign half_pulse = half_q;

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count)); // R3
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (count == $past(count) + W'(1))); // R3
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (count == '0)); // R7
  AST_HALF_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> (count == {1'b1, {(W-1){1'b0}}})); // R7

endmodule

// File: rtl/tsync_evsel.sv
module tsync_evsel
  import tsync_pkg::*;
#(
  parameter int NUM_HW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sw_push,
  input  logic [NUM_HW-1:0] hw_pin,
  input  logic [NUM_HW-1:0] hw_en,
  input  logic              rx_stb,
  input  logic [4:0]        rx_port,
  input  logic [3:0]        rx_msg,
  input  logic [15:0]       rx_seq,
  input  logic              tx_stb,
  input  logic [4:0]        tx_port,
  input  logic [3:0]        tx_msg,
  input  logic [15:0]       tx_seq,
  input  logic              wrap_ev,
  input  logic              half_ev,
  output logic              ev_valid,
  output ev_desc_t          ev_desc,
  output logic              ev_clash
);

  localparam int NREQ = NUM_HW + 5;

  logic [NUM_HW-1:0] pin_q, pin_rise;
  logic [NREQ-1:0]   req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= hw_pin;
  end

  for (genvar g = 0; g < NUM_HW; g++) begin : g_edge
    assign pin_rise[g] = hw_pin[g] && !pin_q[g] && hw_en[g];
  end

  assign req = enable ? {half_ev, wrap_ev, tx_stb, rx_stb, pin_rise, sw_push} : '0;

  always_comb begin
    ev_desc = '0;
    if (half_ev) begin
      ev_desc      = '0;
      ev_desc.kind = EV_HALF;
    end
    if (wrap_ev) begin
      ev_desc      = '0;
      ev_desc.kind = EV_WRAP;
    end
    if (tx_stb) begin
      ev_desc      = '0;
      ev_desc.kind = EV_ETHTX;
      ev_desc.port = tx_port;
      ev_desc.msg  = tx_msg;
      ev_desc.seq  = tx_seq;
    end
    if (rx_stb) begin
      ev_desc      = '0;
      ev_desc.kind = EV_ETHRX;
      ev_desc.port = rx_port;
      ev_desc.msg  = rx_msg;
      ev_desc.seq  = rx_seq;
    end
    for (int i = NUM_HW - 1; i >= 0; i--) begin
      if (pin_rise[i]) begin
        ev_desc      = '0;
        ev_desc.kind = EV_HWPUSH;
        ev_desc.port = 5'(i + 1);
      end
    end
    if (sw_push) begin
      ev_desc      = '0;
      ev_desc.kind = EV_SWPUSH;
    end
  end

  assign ev_valid = |req;
  assign ev_clash = |(req & (req - NREQ'(1)));

endmodule

// File: rtl/tsync_fifo.sv
module tsync_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          wr_ok, rd_ok;

  assign empty = (lvl_q == '0);
  assign full  = (lvl_q == LW'(DEPTH));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (wr_ok) wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (rd_ok) rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (wr_ok && !rd_ok)      lvl_d = lvl_q + LW'(1);
    else if (rd_ok && !wr_ok) lvl_d = lvl_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata;
  end

  assign rdata = mem[rptr_q];
  assign level = lvl_q;

  AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd) |=> full); // R9
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd) |=> $stable(level)); // R9
  AST_POP_EMPTY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr) |=> (empty && $stable(rptr_q))); // R8

endmodule

// File: rtl/tsync_capture.sv
module tsync_capture
  import tsync_pkg::*;
#(
  parameter int          NUM_HW     = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter logic [15:0] ID_IDENT   = 16'h5A17,
  parameter logic [4:0]  ID_RTL     = 5'd3,
  parameter logic [2:0]  ID_MAJOR   = 3'd1,
  parameter logic [7:0]  ID_MINOR   = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_HW-1:0] hw_push_pin,
  input  logic              rx_stb,
  input  logic [4:0]        rx_port,
  input  logic [3:0]        rx_msg,
  input  logic [15:0]       rx_seq,
  input  logic              tx_stb,
  input  logic [4:0]        tx_port,
  input  logic [3:0]        tx_msg,
  input  logic [15:0]       tx_seq,
  output logic              irq
);

  localparam int TS_W = 32;
  localparam int EW   = TS_W + $bits(ev_desc_t);
  localparam int LW   = $clog2(FIFO_DEPTH + 1);

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic              en_q, en_d, test_q, test_d, ien_q, ien_d, drop_q, drop_d;
  logic [NUM_HW-1:0] hwen_q, hwen_d;
  logic [TS_W-1:0]   ldval_q, ldval_d;

  logic sw_push, load_go, pop_go, drop_clr;
  assign sw_push  = bus_wr && (bus_addr == A_PUSH) && bus_wdata[0];
  assign load_go  = bus_wr && (bus_addr == A_LDGO) && bus_wdata[0];
  assign pop_go   = bus_wr && (bus_addr == A_POP)  && bus_wdata[0];
  assign drop_clr = bus_wr && (bus_addr == A_POP)  && bus_wdata[1];

  logic [TS_W-1:0] count;
  logic            wrap_ev, half_ev;

  tsync_counter #(.W(TS_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run(en_q), .load(load_go), .load_val(ldval_q),
    .count(count), .wrap_pulse(wrap_ev), .half_pulse(half_ev)
  );

  logic     ev_valid, ev_clash;
  ev_desc_t ev_desc;

  tsync_evsel #(.NUM_HW(NUM_HW)) u_sel (
    .clk(clk), .rst_n(rst_s), .enable(en_q), .sw_push(sw_push),
    .hw_pin(hw_push_pin), .hw_en(hwen_q),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .wrap_ev(wrap_ev), .half_ev(half_ev),
    .ev_valid(ev_valid), .ev_desc(ev_desc), .ev_clash(ev_clash)
  );

  logic [EW-1:0] head;
  logic          f_empty, f_full;
  logic [LW-1:0] f_level;

  tsync_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .wr(ev_valid), .wdata({count, ev_desc}),
    .rd(pop_go), .rdata(head), .empty(f_empty), .full(f_full), .level(f_level)
  );

  always_comb begin
    en_d    = en_q;
    test_d  = test_q;
    hwen_d  = hwen_q;
    ien_d   = ien_q;
    ldval_d = ldval_q;
    drop_d  = drop_q;
    if (bus_wr && (bus_addr == A_CTRL)) begin
      en_d   = bus_wdata[0];
      test_d = bus_wdata[1];
      hwen_d = bus_wdata[8 +: NUM_HW];
    end
    if (bus_wr && (bus_addr == A_LDVAL)) ldval_d = bus_wdata;
    if (bus_wr && (bus_addr == A_IEN))   ien_d   = bus_wdata[0];
    if (drop_clr) drop_d = 1'b0;
    if (ev_clash || (ev_valid && f_full)) drop_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      en_q    <= 1'b0;
      test_q  <= 1'b0;
      hwen_q  <= '0;
      ien_q   <= 1'b0;
      ldval_q <= '0;
      drop_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      test_q  <= test_d;
      hwen_q  <= hwen_d;
      ien_q   <= ien_d;
      ldval_q <= ldval_d;
      drop_q  <= drop_d;
    end
  end

  logic irq_raw;
  assign irq_raw = !f_empty || test_q;
  assign irq     = irq_raw && ien_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_IDENT:  bus_rdata = {ID_IDENT, ID_RTL, ID_MAJOR, ID_MINOR};
      A_CTRL: begin
        bus_rdata[0]            = en_q;
        bus_rdata[1]            = test_q;
        bus_rdata[8 +: NUM_HW]  = hwen_q;
        bus_rdata[31]           = drop_q;
      end
      A_LDVAL:  bus_rdata = ldval_q;
      A_RAW:    bus_rdata[0] = irq_raw;
      A_MASKED: bus_rdata[0] = irq;
      A_IEN:    bus_rdata[0] = ien_q;
      A_HTIME:  bus_rdata = f_empty ? '0 : head[EW-1 -: TS_W];
      A_HDESC:  bus_rdata = f_empty ? '0 : head[$bits(ev_desc_t)-1:0];
      default:  bus_rdata = '0;
    endcase
  end

  AST_OFF_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_s)
    !en_q |=> (f_level <= $past(f_level))); // R12
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_s)
    (ien_q && !f_empty) |-> irq); // R11
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_s)
    (ev_valid && f_full) |=> drop_q); // R9
  AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_s)
    ev_clash |=> drop_q); // R10

endmodule

// File: tb/tsync_capture_tb_top.sv
`timescale 1ns/100ps
module tsync_capture_tb_top;

  localparam logic [15:0] P_IDENT = 16'h5A17;
  localparam logic [4:0]  P_RTL   = 5'd3;
  localparam logic [2:0]  P_MAJOR = 3'd1;
  localparam logic [7:0]  P_MINOR = 8'd2;

  logic        clk, rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  hw_push_pin;
  logic        rx_stb, tx_stb;
  logic [4:0]  rx_port, tx_port;
  logic [3:0]  rx_msg, tx_msg;
  logic [15:0] rx_seq, tx_seq;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  logic [63:0] exp_q [$];

  tsync_capture #(
    .NUM_HW(4), .FIFO_DEPTH(16),
    .ID_IDENT(P_IDENT), .ID_RTL(P_RTL), .ID_MAJOR(P_MAJOR), .ID_MINOR(P_MINOR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_push_pin(hw_push_pin),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] mk(logic [31:0] t, logic [4:0] port,
                                     logic [3:0] kind, logic [3:0] msg, logic [15:0] seq);
    return {t, 3'b000, port, kind, msg, seq};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_time(logic [31:0] v);
    bus_write(8'h10, v);
    bus_write(8'h14, 32'h1);
  endtask

  // Scoreboard monitor: drains the design's queue and compares with expectations
  task automatic drain(string req);
    logic [31:0] raw, t, d;
    logic [63:0] e;
    for (int n = 0; n < 40; n++) begin
      bus_read(8'h20, raw);
      if (raw[0] == 1'b0) break;
      bus_read(8'h34, t);
      bus_read(8'h38, d);
      if (exp_q.size() == 0) begin
        nchk++;
        nfail++;
        $display("FAIL %s actual=%h_%h expected=<none>", req, t, d);
      end else begin
        e = exp_q.pop_front();
        chk(req, t, e[63:32]);
        chk(req, d, e[31:0]);
      end
      bus_write(8'h30, 32'h1);
    end
    chk(req, 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    hw_push_pin = '0; rx_stb = 0; tx_stb = 0;
    rx_port = '0; rx_msg = '0; rx_seq = '0; tx_port = '0; tx_msg = '0; tx_seq = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    bus_read(8'h04, r); chk("R1 ctrl", r, 32'h0);
    bus_read(8'h20, r); chk("R1 raw", r, 32'h0);
    bus_read(8'h24, r); chk("R1 masked", r, 32'h0);
    bus_read(8'h34, r); chk("R1 time", r, 32'h0);
    bus_read(8'h38, r); chk("R1 desc", r, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    // R2 identification
    bus_read(8'h00, r); chk("R2 ident", r, {P_IDENT, P_RTL, P_MAJOR, P_MINOR});

    // R4 software push, R3 counting
    bus_write(8'h04, 32'h1);
    load_time(32'h0000_1000);
    bus_write(8'h0C, 32'h1);
    exp_q.push_back(mk(32'h0000_1000, 5'd0, 4'd0, 4'd0, 16'h0));
    idle(3);
    bus_write(8'h0C, 32'h1);
    exp_q.push_back(mk(32'h0000_1004, 5'd0, 4'd0, 4'd0, 16'h0));
    drain("R4/R3 push");

    // R3 hold while disabled, R12 no recording while disabled
    load_time(32'h0000_2000);
    bus_write(8'h04, 32'h0);
    rx_stb = 1'b1; rx_port = 5'd2; rx_seq = 16'h0077;
    @(posedge clk); @(negedge clk);
    rx_stb = 1'b0;
    bus_read(8'h20, r); chk("R12 disabled strobe", r, 32'h0);
    idle(4);
    bus_write(8'h04, 32'h1);
    bus_write(8'h0C, 32'h1);
    exp_q.push_back(mk(32'h0000_2001, 5'd0, 4'd0, 4'd0, 16'h0));
    drain("R3 hold");

    // R5 hardware pins: pins 0 and 2 enabled, pin 1 not
    bus_write(8'h04, 32'h0000_0501);
    load_time(32'h0000_3000);
    hw_push_pin[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    hw_push_pin[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    hw_push_pin[2] = 1'b1;
    @(posedge clk); @(negedge clk);
    hw_push_pin = '0;
    exp_q.push_back(mk(32'h0000_3000, 5'd1, 4'd3, 4'd0, 16'h0));
    exp_q.push_back(mk(32'h0000_3002, 5'd3, 4'd3, 4'd0, 16'h0));
    idle(2);
    drain("R5 pins");

    // R6 Ethernet strobes
    load_time(32'h0000_4000);
    rx_stb = 1'b1; rx_port = 5'd5; rx_msg = 4'd3; rx_seq = 16'hBEEF;
    @(posedge clk); @(negedge clk);
    rx_stb = 1'b0;
    tx_stb = 1'b1; tx_port = 5'd7; tx_msg = 4'd9; tx_seq = 16'h1234;
    @(posedge clk); @(negedge clk);
    tx_stb = 1'b0;
    exp_q.push_back(mk(32'h0000_4000, 5'd5, 4'd4, 4'd3, 16'hBEEF));
    exp_q.push_back(mk(32'h0000_4001, 5'd7, 4'd5, 4'd9, 16'h1234));
    drain("R6 eth");

    // R7 wrap and half-wrap markers
    load_time(32'hFFFF_FFFE);
    idle(6);
    exp_q.push_back(mk(32'h0000_0000, 5'd0, 4'd1, 4'd0, 16'h0));
    load_time(32'h7FFF_FFFE);
    idle(6);
    exp_q.push_back(mk(32'h8000_0000, 5'd0, 4'd2, 4'd0, 16'h0));
    drain("R7 markers");

    // R10 simultaneous push and receive
    load_time(32'h0000_5000);
    rx_stb = 1'b1; rx_port = 5'd4; rx_msg = 4'd1; rx_seq = 16'h0042;
    bus_write(8'h0C, 32'h1);
    rx_stb = 1'b0;
    exp_q.push_back(mk(32'h0000_5000, 5'd0, 4'd0, 4'd0, 16'h0));
    bus_read(8'h04, r); chk("R10 lost flag", r, 32'h8000_0501);
    drain("R10 priority");
    bus_write(8'h30, 32'h2);
    bus_read(8'h04, r); chk("R9 flag clear", r, 32'h0000_0501);
    // R8 pop on empty
    bus_write(8'h30, 32'h1);
    bus_read(8'h20, r); chk("R8 pop empty raw", r, 32'h0);
    bus_read(8'h38, r); chk("R8 pop empty desc", r, 32'h0);

    // R9 full queue, R8 ordering
    load_time(32'h0000_6000);
    for (int i = 0; i < 17; i++) begin
      tx_stb = 1'b1; tx_port = 5'd1; tx_msg = 4'd2; tx_seq = 16'(i);
      @(posedge clk); @(negedge clk);
      if (i < 16) exp_q.push_back(mk(32'h0000_6000 + 32'(i), 5'd1, 4'd5, 4'd2, 16'(i)));
    end
    tx_stb = 1'b0;
    bus_read(8'h04, r); chk("R9 overflow flag", r, 32'h8000_0501);
    bus_read(8'h24, r); chk("R11 masked off", r, 32'h0);
    chk("R11 irq masked", 32'(irq), 32'h0);
    drain("R8 order");
    bus_read(8'h04, r); chk("R9 sticky", r, 32'h8000_0501);
    bus_write(8'h30, 32'h2);

    // R11 interrupt
    bus_write(8'h28, 32'h1);
    chk("R11 irq empty", 32'(irq), 32'h0);
    bus_write(8'h04, 32'h0000_0503);
    bus_read(8'h20, r); chk("R11 test raw", r, 32'h1);
    bus_read(8'h24, r); chk("R11 test masked", r, 32'h1);
    chk("R11 test irq", 32'(irq), 32'h1);
    bus_write(8'h04, 32'h0000_0501);
    chk("R11 test off", 32'(irq), 32'h0);
    load_time(32'h0000_7000);
    bus_write(8'h0C, 32'h1);
    exp_q.push_back(mk(32'h0000_7000, 5'd0, 4'd0, 4'd0, 16'h0));
    chk("R11 irq pending", 32'(irq), 32'h1);
    drain("R11 drain");
    chk("R11 irq cleared", 32'(irq), 32'h0);

    finish_run();
  end

endmodule